// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is an 8-bit control register that a CPU writes to request a low-power state or an internal reset. It also shapes a CPU clock-enable for intermittent operation. Some fields are commands. Writing the active value produces a one-cycle request strobe toward the clock-control logic for stop, sleep or timer-only mode, or starts a fixed three-cycle internal reset pulse. Writing the inactive value does nothing, and these command fields always read back as their inactive values.

The other fields are stored. The pin-state field tells the pad logic whether outputs hold their level or go high-impedance while in stop or timer-only mode. The two halt-select bits program how many cycles the CPU clock-enable is dropped after each run period of `RUN_LEN` cycles.

When one write asks for several modes, only the highest-priority one is strobed. A reset request on the same write cancels every mode strobe.

Top module: `lpm_ctrl_reg`

## Requirements
- R1: After reset the register reads 8'h18, all strobes and `int_rst` are 0, `pins_hiz` is 0 and `cpu_clk_en` is 1.
- R2: Bits 7 and 6 always read 0 and bits 4 and 3 always read 1; bit 5, bits 2:1 and bit 0 read back the value last written to them.
- R3: Writing 1 to bit 7 (stop) raises `stop_req` for exactly the one cycle after the write edge. Writing 0 to bit 7 raises nothing.
- R4: Writing 1 to bit 6 (sleep) raises `sleep_req` for exactly the one cycle after the write edge. Writing 0 to bit 6 raises nothing.
- R5: Writing 0 to bit 3 (timer-only mode, active low) raises `timer_req` for exactly the one cycle after the write edge. Writing 1 to bit 3 raises nothing.
- R6: When one write requests several modes, only one strobe rises. Stop wins over timer-only, and timer-only wins over sleep.
- R7: Writing 0 to bit 4 (reset, active low) drives `int_rst` high for exactly 3 cycles after the write edge and suppresses every mode strobe of that write.
- R8: `pins_hiz` equals bit 5 as last written (0 = hold pins, 1 = high-impedance).
- R9: With halt-select bits 2:1 = 00, `cpu_clk_en` stays 1 permanently.
- R10: With halt-select 01, 10 or 11, `cpu_clk_en` repeats a pattern of `RUN_LEN` cycles high followed by 9, 17 or 33 cycles low, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| stop_req | output | 1 | One-cycle stop-mode request |
| sleep_req | output | 1 | One-cycle sleep-mode request |
| timer_req | output | 1 | One-cycle timer-only-mode request |
| pins_hiz | output | 1 | Pin high-impedance select for stop and timer-only modes |
| int_rst | output | 1 | Internal reset pulse of 3 cycles |
| cpu_clk_en | output | 1 | CPU clock-enable for intermittent operation |

## Verification
The mode decode is exercised in three ways.
- Each command bit is written alone at its active value, which shows that each strobe comes from its own bit.
- An all-inactive pattern is written, which shows that inactive values are ignored.
- Multi-request patterns are written, which separate a correct priority order from a wrong one and show that a reset request cancels the strobes.

The intermittent sequencer is measured under all four halt selections by counting the high and low runs of `cpu_clk_en`. A wrong halt-length table or an off-by-one in either phase shows up as a wrong count.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Bit positions that software decodes
    localparam int BIT_STOP  = 7;
    localparam int BIT_SLEEP = 6;
    localparam int BIT_HIZ   = 5;
    localparam int BIT_RSTN  = 4;
    localparam int BIT_TMRN  = 3;
    localparam int BIT_SELH  = 2;
    localparam int BIT_SELL  = 1;
    localparam int BIT_RESV  = 0;

    localparam int HALT_MAX = 33;

    typedef struct packed {
        logic       hiz;
        logic [1:0] sel;
        logic       resv;
    } cfg_t;

    typedef struct packed {
        logic stop;
        logic timer;
        logic sleep;
    } req_t;

    typedef enum logic {PH_RUN = 1'b0, PH_HALT = 1'b1} phase_e;

    // Halt length: 0, 9, 17, 33 for selections 0..3
    function automatic int unsigned halt_len(input logic [1:0] sel);
        if (sel == 2'd0)
            return 0;
        return (32'd4 << sel) + 32'd1;
    endfunction

    // Mode priority: stop > timer-only > sleep
    function automatic req_t pick_req(input logic stop_b, input logic tmr_b, input logic slp_b);
        req_t r;
        r.stop  = stop_b;
        r.timer = tmr_b & ~stop_b;
        r.sleep = slp_b & ~stop_b & ~tmr_b;
        return r;
    endfunction

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output cfg_t       cfg,
    output req_t       req,
    output logic       rst_trig,
    output logic [7:0] rdata
);
    cfg_t cfg_q;
    req_t req_q;
    req_t req_d;
    logic rst_wr;

    assign rst_wr = we & ~wdata[BIT_RSTN];

    always_comb begin
        req_d = pick_req(wdata[BIT_STOP], ~wdata[BIT_TMRN], wdata[BIT_SLEEP]);
        if (!we || rst_wr)
            req_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            req_q <= '0;
        end else begin
            req_q <= req_d;
            if (we) begin
                cfg_q.hiz  <= wdata[BIT_HIZ];
                cfg_q.sel  <= {wdata[BIT_SELH], wdata[BIT_SELL]};
                cfg_q.resv <= wdata[BIT_RESV];
            end
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[BIT_HIZ]   = cfg_q.hiz;
        rdata[BIT_RSTN]  = 1'b1;
        rdata[BIT_TMRN]  = 1'b1;
        rdata[BIT_SELH]  = cfg_q.sel[1];
        rdata[BIT_SELL]  = cfg_q.sel[0];
        rdata[BIT_RESV]  = cfg_q.resv;
    end

    assign cfg      = cfg_q;
    assign req      = req_q;
    assign rst_trig = rst_wr;
endmodule

// File: rtl/lpm_rst_gen.sv
module lpm_rst_gen #(
    parameter int RST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (trig)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign pulse = (cnt != '0);
endmodule

// File: rtl/lpm_halt_seq.sv
module lpm_halt_seq
    import lpm_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       clk_en
);
    localparam int MAXC = (RUN_LEN > HALT_MAX) ? RUN_LEN : HALT_MAX;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] hlen;

    assign hlen = CW'(halt_len(sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RUN;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_RUN: begin
                    if (cnt == RUN_LAST) begin
                        cnt <= '0;
                        if (hlen != '0) begin
                            phase <= PH_HALT;
                            cnt   <= hlen - 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HALT: begin
                    if (sel == 2'd0 || cnt == '0) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign clk_en = (phase == PH_RUN) || (sel == 2'd0);
endmodule

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg
    import lpm_pkg::*;
#(
    parameter int RUN_LEN    = 4,
    parameter int RST_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       stop_req,
    output logic       sleep_req,
    output logic       timer_req,
    output logic       pins_hiz,
    output logic       int_rst,
    output logic       cpu_clk_en
);
    cfg_t cfg;
    req_t req;
    logic rst_trig;

    lpm_cfg_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .cfg      (cfg),
        .req      (req),
        .rst_trig (rst_trig),
        .rdata    (bus_rdata)
    );

    lpm_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst   (rst),
        .trig  (rst_trig),
        .pulse (int_rst)
    );

    lpm_halt_seq #(.RUN_LEN(RUN_LEN)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .sel    (cfg.sel),
        .clk_en (cpu_clk_en)
    );

    assign stop_req  = req.stop;
    assign sleep_req = req.sleep;
    assign timer_req = req.timer;
    assign pins_hiz  = cfg.hiz;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       stop_req,
    input logic       sleep_req,
    input logic       timer_req,
    input logic       pins_hiz,
    input logic       int_rst,
    input logic       cpu_clk_en
);
    p_onehot_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stop_req, sleep_req, timer_req}));

    p_stop_cause_r3: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> $past(bus_we && bus_wdata[7] && bus_wdata[4]));

    p_rst_start_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_wdata[4]) |=> (int_rst && !stop_req && !sleep_req && !timer_req));

    p_hiz_follow_r8: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> (pins_hiz == $past(bus_wdata[5])));

    p_clken_on_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[2:1] == 2'b00) |-> cpu_clk_en);

    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> (bus_rdata[7:6] == 2'b00 && bus_rdata[4:3] == 2'b11));
endmodule

bind lpm_ctrl_reg lpm_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .stop_req   (stop_req),
    .sleep_req  (sleep_req),
    .timer_req  (timer_req),
    .pins_hiz   (pins_hiz),
    .int_rst    (int_rst),
    .cpu_clk_en (cpu_clk_en)
);

// File: tb/tb_lpm_ctrl_reg.sv
`timescale 1ns/1ps
module tb_lpm_ctrl_reg;
    localparam int RUN_LEN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_req, sleep_req, timer_req, pins_hiz, int_rst, cpu_clk_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lpm_ctrl_reg #(.RUN_LEN(RUN_LEN), .RST_CYCLES(3)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .stop_req(stop_req), .sleep_req(sleep_req),
        .timer_req(timer_req), .pins_hiz(pins_hiz), .int_rst(int_rst),
        .cpu_clk_en(cpu_clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a write for one edge; returns at the negedge just after it
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic int strobes();
        return {29'd0, stop_req, timer_req, sleep_req};
    endfunction

    task automatic t_reset();
        check("R1 rdata", bus_rdata, 8'h18);
        check("R1 strobes", strobes(), 0);
        check("R1 int_rst", int_rst, 0);
        check("R1 pins_hiz", pins_hiz, 0);
        check("R1 cpu_clk_en", cpu_clk_en, 1);
    endtask

    task automatic t_readback();
        wr(8'hE7);
        check("R2 readback ones", bus_rdata, 8'h3F);
        check("R8 hiz set", pins_hiz, 1);
        @(negedge clk);
        wr(8'h18);
        check("R2 readback zeros", bus_rdata, 8'h18);
        check("R8 hiz clear", pins_hiz, 0);
    endtask

    // Single command strobe: check for one cycle then cleared
    task automatic t_single(input string req, input logic [7:0] d, input int exp);
        wr(d);
        check({req, " strobe"}, strobes(), exp);
        @(negedge clk);
        check({req, " one cycle"}, strobes(), 0);
    endtask

    task automatic t_idle();
        wr(8'h19);
        check("R3 R4 R5 inactive write", strobes(), 0);
        check("R7 inactive rst", int_rst, 0);
        @(negedge clk);
        check("R3 R4 R5 inactive later", strobes(), 0);
    endtask

    task automatic t_priority();
        t_single("R6 stop+timer+sleep", 8'hD1, 4);
        t_single("R6 timer+sleep", 8'h51, 2);
        t_single("R6 stop+sleep", 8'hD9, 4);
    endtask

    task automatic t_int_reset();
        wr(8'hC1);
        check("R7 rst c1", int_rst, 1);
        check("R7 strobes cancelled", strobes(), 0);
        @(negedge clk);
        check("R7 rst c2", int_rst, 1);
        @(negedge clk);
        check("R7 rst c3", int_rst, 1);
        @(negedge clk);
        check("R7 rst end", int_rst, 0);
    endtask

    task automatic t_halt(input string req, input logic [1:0] sel, input int exp_low);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        wr({5'b00011, sel, 1'b1});
        if (exp_low == 0) begin
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (!cpu_clk_en) lo++;
            end
            check({req, " always on"}, lo, 0);
        end else begin
            while (cpu_clk_en && guard < 200) begin @(negedge clk); guard++; end
            while (!cpu_clk_en && guard < 200) begin @(negedge clk); guard++; end
            while (cpu_clk_en && guard < 200) begin hi++; @(negedge clk); guard++; end
            while (!cpu_clk_en && guard < 200) begin lo++; @(negedge clk); guard++; end
            check({req, " run len"}, hi, RUN_LEN);
            check({req, " halt len"}, lo, exp_low);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R10 watchdog actual=hang expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_single("R3 stop", 8'h99, 4);
        t_single("R4 sleep", 8'h59, 1);
        t_single("R5 timer", 8'h11, 2);
        t_idle();
        t_priority();
        t_int_reset();
        t_halt("R9 sel00", 2'b00, 0);
        t_halt("R10 sel01", 2'b01, 9);
        t_halt("R10 sel10", 2'b10, 17);
        t_halt("R10 sel11", 2'b11, 33);
        t_halt("R9 back to sel00", 2'b00, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule